// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a clocked single-port static memory. It holds a small array of words, and each word is split into byte lanes. On every rising clock edge it samples an address, a chip enable, two address strobes, an advance input and a set of write controls. Either strobe loads a new base address, which opens a burst. After that, the two low address bits come from a 2-bit beat counter. The counter moves forward only on cycles where advance is high. A static order input selects one of two burst orders: a linear count that wraps inside an aligned group of four, or the start offset XORed with the beat number. A new address can be strobed on every cycle, so random access runs at full rate.

There are two write modes. A whole-word write stores every lane. A byte write stores only the selected lanes. A static read-mode input selects how read data reaches the output. In registered mode the data passes through an output register, so it appears one edge later than in flow-through mode. In flow-through mode the register is bypassed. Read data leaves the block on a separate output bus together with a drive flag. The flag is low when output enable is low, when the sleep input is high, and for one cycle after a write is captured. Deselect follows single-cycle rules: the drive flag falls as soon as no read is left in the output path.

Top module: `burst_sram`

## Requirements
- R1: On a cycle with `ld_p` or `ld_c` high and `ce` high, the address on `addr` is loaded as the burst base and is accessed on that same edge. A new address may be loaded on consecutive edges, and each load is accessed with no idle cycle between them.
- R2: On a cycle where `ld_p` is high, the access is a read, whatever the write controls say. Write controls are honoured only on `ld_c` cycles (with `ld_p` low) and on burst continuation cycles.
- R3: With `lin_order` high, beat n of a burst addresses `{base[ADDR_W-1:2], base[1:0]+n mod 4}`.
- R4: With `lin_order` low, beat n of a burst addresses `{base[ADDR_W-1:2], base[1:0] XOR n}`.
- R5: While a burst is open and no strobe is given, a cycle with `adv` high moves to the next beat. A cycle with `adv` low accesses the current beat again (a wait state). When no burst is open (after reset or after a deselect), `adv` and the write controls cause no access and no write.
- R6: `gw` high writes all lanes of `wdata`, whatever the values of `bwe` and `bsel`.
- R7: With `gw` low and `bwe` high, only lanes whose `bsel` bit is high are written (bit i covers `wdata[8i+7:8i]`). If no lane is selected, the cycle is a read.
- R8: With `pipe_mode` low, the data of a read captured at edge k is on `rdata`, with `rd_drv` high, right after edge k.
- R9: With `pipe_mode` high, the data of a read captured at edge k appears right after edge k+1. Right after edge k, the flag reflects only the access captured at edge k-1.
- R10: A strobe with `ce` low ends the burst. With `pipe_mode` low, `rd_drv` is low right after that edge. With `pipe_mode` high, the read captured one edge earlier stays valid until the next edge, and `rd_drv` is low after that.
- R11: `rd_drv` is low whenever `oe` is low, and this acts immediately, without waiting for a clock. It is also low right after an edge that captured a write. Whenever `rd_drv` is low, `rdata` is all zeros.
- R12: While `sleep` is high, `rd_drv` is low at once, and edges take no command. Array contents and the open burst (base and beat) are kept, so the burst can go on after `sleep` falls.
- R13: After reset, no burst is open and `rd_drv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address loaded by a strobe |
| ce | input | 1 | Chip enable; a strobe with it low deselects |
| ld_p | input | 1 | Address strobe whose cycle is always a read |
| ld_c | input | 1 | Address strobe that honours the write controls |
| adv | input | 1 | Step the beat counter of an open burst |
| gw | input | 1 | Whole-word write |
| bwe | input | 1 | Byte write enable |
| bsel | input | LANES | Per-lane byte select |
| wdata | input | LANES*LANE_W | Write data |
| lin_order | input | 1 | Static burst order: 1 linear, 0 XOR |
| pipe_mode | input | 1 | Static read mode: 1 registered, 0 flow-through |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep: commands ignored, output off, contents kept |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rd_drv | output | 1 | Read data is being driven |

## Verification
The properties assume that `pipe_mode` and `lin_order` change only while no access is in flight. They also assume that `oe` and `sleep` settle before the edge at which they are sampled, because the checker sees these asynchronous inputs only at clock edges. The stimulus changes modes only after two deselect cycles have drained the output path. It drives every input at the falling edge and never leaves a burst open across a mode change. Reads check only locations the bench has already written, so the uninitialised array never feeds an expected value.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // Kind of array access issued on a clock edge.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  localparam int BEAT_W = 2;

  // Low address bits for a beat: linear count or XOR with the start offset.
  function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] start,
                                                input logic [BEAT_W-1:0] beat,
                                                input logic              linear);
    beat_lo = linear ? BEAT_W'(start + beat) : (start ^ beat);
  endfunction

endpackage

// File: rtl/bsram_wr_decode.sv
module bsram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             gw,
  input  logic             bwe,
  input  logic [LANES-1:0] bsel,
  output logic [LANES-1:0] lane_we,
  output logic             wr_req
);

  // Whole-word write overrides the per-lane selects.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = gw | (bwe & bsel[l]);
  end

  assign wr_req = |lane_we;

endmodule

// File: rtl/bsram_addr_ctl.sv
module bsram_addr_ctl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              ce,
  input  logic              ld_p,
  input  logic              ld_c,
  input  logic              adv,
  input  logic              lin_order,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d, beat_step;
  logic              open_q, open_d;
  logic              st_en;

  assign beat_step = beat_q + BEAT_W'(adv);
  assign st_en     = ~sleep;

  always_comb begin
    base_d   = base_q;
    beat_d   = beat_q;
    open_d   = open_q;
    acc      = ACC_NONE;
    acc_addr = base_q;
    if (!sleep) begin
      if (ld_p || ld_c) begin
        if (ce) begin
          base_d   = addr;
          beat_d   = '0;
          open_d   = 1'b1;
          acc_addr = addr;
          acc      = (ld_c && !ld_p && wr_req) ? ACC_WRITE : ACC_READ;
        end else begin
          open_d = 1'b0;
        end
      end else if (open_q) begin
        beat_d   = beat_step;
        acc_addr = {base_q[ADDR_W-1 -: HI_W],
                    beat_lo(base_q[BEAT_W-1:0], beat_step, lin_order)};
        acc      = wr_req ? ACC_WRITE : ACC_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      open_q <= 1'b0;
    end else if (st_en) begin
      base_q <= base_d;
      beat_q <= beat_d;
      open_q <= open_d;
    end
  end

endmodule

// File: rtl/bsram_core.sv
module bsram_core #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // One storage array per lane keeps each write process on its own variable.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_we[l]) begin
        lane_mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = lane_mem[raddr];
  end

endmodule

// File: rtl/bsram_rd_path.sv
module bsram_rd_path
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              sleep,
  input  logic [WORD_W-1:0] arr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_drv
);

  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, rd_d;
  logic              wr_q, wr_d;
  logic              drv_q;
  logic [WORD_W-1:0] dout_q;
  logic              addr_en;
  logic              drv_int;
  logic [WORD_W-1:0] data_int;

  always_comb begin
    rd_d    = (acc == ACC_READ);
    wr_d    = (acc == ACC_WRITE);
    addr_en = (acc != ACC_NONE);
  end

  // Input-side access registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
      if (addr_en) begin
        addr_q <= acc_addr;
      end
    end
  end

  // Output register stage used in registered mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      drv_q <= rd_q;
      if (rd_q) begin
        dout_q <= arr_data;
      end
    end
  end

  always_comb begin
    drv_int  = pipe_mode ? drv_q : rd_q;
    data_int = pipe_mode ? dout_q : arr_data;
    rd_drv   = drv_int & ~wr_q & oe & ~sleep;
    rdata    = rd_drv ? data_int : '0;
  end

  assign rd_addr = addr_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce,
  input  logic                    ld_p,
  input  logic                    ld_c,
  input  logic                    adv,
  input  logic                    gw,
  input  logic                    bwe,
  input  logic [LANES-1:0]        bsel,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    lin_order,
  input  logic                    pipe_mode,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_drv
);

  localparam int WORD_W = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [LANES-1:0]  lane_we;
  logic              wr_req;
  acc_e              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] arr_data;
  logic              arr_we;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  bsram_wr_decode #(.LANES(LANES)) i_wr_decode (
    .gw      (gw),
    .bwe     (bwe),
    .bsel    (bsel),
    .lane_we (lane_we),
    .wr_req  (wr_req)
  );

  bsram_addr_ctl #(.ADDR_W(ADDR_W)) i_addr_ctl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .sleep     (sleep),
    .ce        (ce),
    .ld_p      (ld_p),
    .ld_c      (ld_c),
    .adv       (adv),
    .lin_order (lin_order),
    .wr_req    (wr_req),
    .addr      (addr),
    .acc       (acc),
    .acc_addr  (acc_addr)
  );

  assign arr_we = (acc == ACC_WRITE);

  bsram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_core (
    .clk     (clk),
    .we      (arr_we),
    .lane_we (lane_we),
    .waddr   (acc_addr),
    .wdata   (wdata),
    .raddr   (rd_addr),
    .rdata   (arr_data)
  );

  bsram_rd_path #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_rd_path (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .acc       (acc),
    .acc_addr  (acc_addr),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .sleep     (sleep),
    .arr_data  (arr_data),
    .rd_addr   (rd_addr),
    .rdata     (rdata),
    .rd_drv    (rd_drv)
  );

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce,
  input logic                    ld_p,
  input logic                    ld_c,
  input logic                    gw,
  input logic                    bwe,
  input logic [LANES-1:0]        bsel,
  input logic                    pipe_mode,
  input logic                    oe,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic                    rd_drv
);

  a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rd_drv);

  a_r12_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_drv);

  a_r11_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drv |-> (rdata == '0));

  a_r11_write_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && ld_c && !ld_p && ce && (gw || (bwe && (|bsel)))) |=> !rd_drv);

  a_r10_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && (ld_p || ld_c) && !ce && !pipe_mode) |=> !rd_drv);

  a_r10_pipe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && (ld_p || ld_c) && !ce && pipe_mode) ##1 pipe_mode |=> !rd_drv);

  a_r2_p_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && ld_p && ce && !pipe_mode) |=> (!oe || sleep || rd_drv));

endmodule

bind burst_sram bsram_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_bsram_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce        (ce),
  .ld_p      (ld_p),
  .ld_c      (ld_c),
  .gw        (gw),
  .bwe       (bwe),
  .bsel      (bsel),
  .pipe_mode (pipe_mode),
  .oe        (oe),
  .sleep     (sleep),
  .rdata     (rdata),
  .rd_drv    (rd_drv)
);

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        ce, ld_p, ld_c, adv, gw, bwe;
  logic [3:0]  bsel;
  logic [31:0] wdata;
  logic        lin_order, pipe_mode, oe, sleep;
  logic [31:0] rdata;
  logic        rd_drv;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;
  logic [31:0] ref_mem [256];

  always #2.5 clk = ~clk;

  burst_sram i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce(ce), .ld_p(ld_p), .ld_c(ld_c),
    .adv(adv), .gw(gw), .bwe(bwe), .bsel(bsel), .wdata(wdata),
    .lin_order(lin_order), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rd_drv(rd_drv)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    addr = '0; ce = 0; ld_p = 0; ld_c = 0; adv = 0;
    gw = 0; bwe = 0; bsel = '0; wdata = '0;
  endtask

  task automatic exp_on(input string req, input logic [31:0] exp);
    nvec++;
    if (rd_drv !== 1'b1 || rdata !== exp) begin
      nerr++;
      $display("FAIL %s: drive=%b data=%h, expected drive=1 data=%h", req, rd_drv, rdata, exp);
    end
  endtask

  task automatic exp_off(input string req);
    nvec++;
    if (rd_drv !== 1'b0 || rdata !== 32'h0) begin
      nerr++;
      $display("FAIL %s: drive=%b data=%h, expected drive=0 data=00000000", req, rd_drv, rdata);
    end
  endtask

  function automatic logic [7:0] beat_addr(input logic [7:0] base, input int beat, input bit lin);
    logic [1:0] b = 2'(beat);
    return {base[7:2], lin ? 2'(base[1:0] + b) : (base[1:0] ^ b)};
  endfunction

  // Deselect twice so both read paths are drained.
  task automatic end_burst();
    clr(); ld_c = 1; tick(); tick(); clr();
  endtask

  task automatic strobe_read(input logic [7:0] a, input bit use_p);
    clr(); ce = 1; addr = a;
    if (use_p) ld_p = 1; else ld_c = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; clr(); oe = 1; sleep = 0; lin_order = 1; pipe_mode = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    exp_off("R13 idle after reset");
    adv = 1; gw = 1; tick();
    exp_off("R13 R5 advance with no open burst");
    clr();
  endtask

  task automatic t_fill();
    for (int a = 0; a < 256; a++) begin
      clr(); ld_c = 1; ce = 1; gw = 1; addr = 8'(a);
      wdata = {8'(a), ~8'(a), 8'(a) ^ 8'h5a, 8'hc3};
      ref_mem[a] = wdata;
      tick();
    end
    end_burst();
  endtask

  task automatic t_flow_linear();
    pipe_mode = 0; lin_order = 1;
    strobe_read(8'h4e, 1); tick();
    exp_on("R8 R3 flow beat0", ref_mem[8'h4e]);
    clr(); adv = 1;
    for (int b = 1; b < 4; b++) begin
      tick();
      exp_on("R3 linear beat", ref_mem[beat_addr(8'h4e, b, 1)]);
    end
    clr(); ld_c = 1; tick();
    exp_off("R10 flow deselect");
    end_burst();
  endtask

  task automatic t_pipe_interleave();
    pipe_mode = 0; lin_order = 0; tick(); pipe_mode = 1; tick();
    strobe_read(8'h91, 1); tick();
    exp_off("R9 pipe data not yet out");
    clr(); adv = 1;
    for (int b = 1; b < 4; b++) begin
      tick();
      exp_on("R9 R4 interleaved beat", ref_mem[beat_addr(8'h91, b - 1, 0)]);
    end
    clr(); ld_c = 1; tick();
    exp_on("R10 pipe last beat held", ref_mem[beat_addr(8'h91, 3, 0)]);
    tick();
    exp_off("R10 pipe deselect");
    end_burst();
  endtask

  task automatic t_random(input bit pm);
    logic [7:0] prev = '0;
    pipe_mode = pm; lin_order = 1; tick();
    for (int i = 0; i < 20; i++) begin
      logic [7:0] a = 8'($urandom_range(255));
      strobe_read(a, i[0]); tick();
      if (!pm) exp_on("R1 back-to-back flow", ref_mem[a]);
      else if (i > 0) exp_on("R1 back-to-back pipe", ref_mem[prev]);
      prev = a;
    end
    clr(); ld_c = 1; tick();
    if (pm) exp_on("R1 R10 pipe final", ref_mem[prev]);
    else exp_off("R10 flow final");
    end_burst();
  endtask

  task automatic t_writes();
    pipe_mode = 0; lin_order = 1; tick();
    clr(); ld_c = 1; ce = 1; addr = 8'h20; bwe = 1; bsel = 4'b0101; wdata = 32'haabbccdd;
    for (int l = 0; l < 4; l++) if (bsel[l]) ref_mem[8'h20][8*l +: 8] = wdata[8*l +: 8];
    tick();
    exp_off("R11 drive off after write");
    strobe_read(8'h20, 1); tick();
    exp_on("R7 selected lanes only", ref_mem[8'h20]);
    clr(); ld_c = 1; ce = 1; addr = 8'h21; gw = 1; bwe = 1; bsel = 4'b0001; wdata = 32'h11223344;
    ref_mem[8'h21] = wdata; tick();
    strobe_read(8'h21, 0); tick();
    exp_on("R6 global write overrides lanes", ref_mem[8'h21]);
    clr(); ld_c = 1; ce = 1; addr = 8'h22; bwe = 1; bsel = 4'b0000; wdata = 32'hdeadbeef;
    tick();
    exp_on("R7 no lane selected reads", ref_mem[8'h22]);
    clr(); ld_c = 1; ce = 1; addr = 8'h33; gw = 1;
    for (int b = 0; b < 4; b++) begin
      wdata = 32'hf0f00000 + 32'(b);
      ref_mem[beat_addr(8'h33, b, 1)] = wdata;
      tick();
      ld_c = 0; adv = 1;
    end
    end_burst();
    for (int b = 0; b < 4; b++) begin
      strobe_read(beat_addr(8'h33, b, 1), 1); tick();
      exp_on("R6 R3 write burst stored", ref_mem[beat_addr(8'h33, b, 1)]);
    end
    clr(); ld_p = 1; ce = 1; addr = 8'h40; gw = 1; ld_c = 1; wdata = 32'h0;
    tick();
    exp_on("R2 strobe p ignores writes", ref_mem[8'h40]);
    strobe_read(8'h40, 0); tick();
    exp_on("R2 location unchanged", ref_mem[8'h40]);
    end_burst();
  endtask

  task automatic t_wait();
    pipe_mode = 0; lin_order = 1;
    strobe_read(8'h57, 0); tick();
    exp_on("R5 beat0", ref_mem[8'h57]);
    clr(); tick();
    exp_on("R5 wait holds beat", ref_mem[8'h57]);
    adv = 1; tick();
    exp_on("R5 advance after wait", ref_mem[8'h54]);
    adv = 0; tick();
    exp_on("R5 second wait", ref_mem[8'h54]);
    clr(); ld_c = 1; tick();
    clr(); adv = 1; gw = 1; wdata = 32'h0; tick();
    exp_off("R5 advance after deselect ignored");
    tick();
    end_burst();
    strobe_read(8'h55, 0); tick();
    exp_on("R5 no stray write 55", ref_mem[8'h55]);
    strobe_read(8'h56, 0); tick();
    exp_on("R5 no stray write 56", ref_mem[8'h56]);
    end_burst();
  endtask

  task automatic t_oe_and_turn();
    pipe_mode = 0;
    strobe_read(8'h60, 0); tick();
    exp_on("R11 before oe drop", ref_mem[8'h60]);
    oe = 0; #1;
    exp_off("R11 async oe off");
    oe = 1; #1;
    exp_on("R11 oe restored", ref_mem[8'h60]);
    end_burst();
    pipe_mode = 1; tick();
    strobe_read(8'h61, 1); tick();
    clr(); ld_c = 1; ce = 1; addr = 8'h62; gw = 1; wdata = 32'h0badf00d;
    ref_mem[8'h62] = wdata; tick();
    exp_off("R11 pipe write turnaround");
    clr(); ld_c = 1; tick();
    exp_off("R11 R10 after turnaround");
    strobe_read(8'h62, 0); tick();
    clr(); ld_c = 1; tick();
    exp_on("R9 pipe read of written word", ref_mem[8'h62]);
    end_burst();
  endtask

  task automatic t_sleep();
    pipe_mode = 0; lin_order = 1; tick();
    strobe_read(8'h70, 0); tick();
    exp_on("R12 before sleep", ref_mem[8'h70]);
    sleep = 1; #1;
    exp_off("R12 sleep turns output off");
    clr(); ld_c = 1; ce = 1; addr = 8'h70; gw = 1; wdata = 32'h0; tick();
    exp_off("R12 command ignored in sleep");
    clr(); adv = 1; tick();
    sleep = 0; #1;
    exp_off("R12 nothing in flight after sleep");
    tick();
    exp_on("R12 burst resumes", ref_mem[8'h71]);
    end_burst();
    strobe_read(8'h70, 1); tick();
    exp_on("R12 contents retained", ref_mem[8'h70]);
    end_burst();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_flow_linear();
    t_pipe_interleave();
    t_random(1'b0);
    t_random(1'b1);
    t_writes();
    t_wait();
    t_oe_and_turn();
    t_sleep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule